// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block is a 64-bit integer adder and subtractor built from a single carry chain. The chain can be cut at byte, half-word or word boundaries, so one operation works on several packed integers at once. A two-bit lane-size input picks the packing: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. The packing is set by this input alone. No length register is involved, no per-lane enable exists, and every lane always writes its result.

A single control bit selects addition or subtraction for all lanes together. Subtraction inverts the second operand and injects a carry of one at the lowest bit of every active lane. Each lane wraps modulo two to the lane width, with no saturation. The block also reports the carry out of each lane. The datapath is combinational. An optional output register, on by default, holds the packed result and the carry vector.

Top module: `simd_lane_adder`

## Requirements
- R1: While `rst_n` is low, `sum_o` and `carry_o` read zero when the output register is present.
- R2: With the output register present, the result for operands applied before a rising clock edge appears on `sum_o` and `carry_o` after that edge and holds until the next edge.
- R3: With `mode_i` = 2'b00, byte i of the result (bits 8i+7..8i) is byte i of `a_i` combined with byte i of `b_i`, modulo 256, and no carry crosses a byte boundary.
- R4: With `mode_i` = 2'b01, each 16-bit half-word lane (bits 16j+15..16j) is computed modulo 2^16, independently of the other half-words.
- R5: With `mode_i` = 2'b10, the low and high 32-bit words are computed independently, modulo 2^32.
- R6: With `mode_i` = 2'b11, the whole 64-bit word is one lane, computed modulo 2^64.
- R7: With `sub_i` = 1, every lane yields a minus b modulo its lane size. With `sub_i` = 0, every lane yields a plus b.
- R8: The carry out of lane i, whose width is L bits, appears on `carry_o` bit (i+1)·L/8 − 1. For an addition this carry is the unsigned overflow of the lane. For a subtraction it is 1 exactly when the lane of `a_i` is not smaller than the lane of `b_i`, taken unsigned.
- R9: Every bit of `carry_o` that is not the top byte of an active lane reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Lane size: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit |
| sub_i | input | 1 | 1 selects subtraction, 0 selects addition |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| sum_o | output | 64 | Packed result |
| carry_o | output | 8 | Per-byte carry slots; only lane-top bytes carry a value |

## Verification
With the default output register, each result is due exactly one rising edge after its operands are presented. The operands are driven on a falling edge, and the register captures them on the following rising edge. The checks then read `sum_o` and `carry_o` on the next falling edge, half a period after the capture, so no check depends on the ordering of processes at a clock edge. The expected values come from a lane-by-lane model in the bench. That model builds its own masks for each lane width and does not use the byte chain.

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int WIDTH   = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               sub_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [WIDTH-1:0]   sum_o,
  output logic [WIDTH/8-1:0] carry_o
);
  localparam int NB   = WIDTH / 8;
  localparam int HALF = WIDTH / 2;

  logic [NB-1:0]    lane_lo, lane_hi, cin, cout;
  logic [WIDTH-1:0] comb_sum;
  logic [NB-1:0]    comb_carry;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [8:0] part;

    assign lane_lo[k] = (k == 0) || (mode_i == 2'b00) ||
                        (mode_i == 2'b01 && (k % 2) == 0) ||
                        (mode_i == 2'b10 && (k % (NB/2)) == 0);
    assign lane_hi[k] = (k == NB-1) || (mode_i == 2'b00) ||
                        (mode_i == 2'b01 && (k % 2) == 1) ||
                        (mode_i == 2'b10 && (k % (NB/2)) == (NB/2)-1);

    if (k == 0) begin : g_first
      assign cin[k] = sub_i;
    end else begin : g_rest
      assign cin[k] = lane_lo[k] ? sub_i : cout[k-1];
    end

    assign part = {1'b0, a_i[8*k +: 8]} + {1'b0, b_i[8*k +: 8] ^ {8{sub_i}}} + {8'd0, cin[k]};
    assign comb_sum[8*k +: 8] = part[7:0];
    assign cout[k]            = part[8];
    assign comb_carry[k]      = lane_hi[k] & cout[k];

    assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00) |-> comb_sum[8*k +: 8] ==
        (sub_i ? a_i[8*k +: 8] - b_i[8*k +: 8] : a_i[8*k +: 8] + b_i[8*k +: 8]));
  end

  for (genvar j = 0; j < NB/2; j++) begin : g_half
    assert_half_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01) |-> comb_sum[16*j +: 16] ==
        (sub_i ? a_i[16*j +: 16] - b_i[16*j +: 16] : a_i[16*j +: 16] + b_i[16*j +: 16]));
  end

  for (genvar w = 0; w < 2; w++) begin : g_word
    assert_word_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b10) |-> comb_sum[HALF*w +: HALF] ==
        (sub_i ? a_i[HALF*w +: HALF] - b_i[HALF*w +: HALF] : a_i[HALF*w +: HALF] + b_i[HALF*w +: HALF]));
  end

  assert_full_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |-> comb_sum == (sub_i ? a_i - b_i : a_i + b_i));

  assert_borrow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && sub_i) |-> comb_carry[NB-1] == (a_i >= b_i));

  assert_unused_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |-> comb_carry[NB-2:0] == '0);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_o   <= '0;
        carry_o <= '0;
      end else begin
        sum_o   <= comb_sum;
        carry_o <= comb_carry;
      end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ##0 1'b1 ##1 (sum_o == $past(comb_sum) && carry_o == $past(comb_carry)));
  end else begin : g_comb
    assign sum_o   = comb_sum;
    assign carry_o = comb_carry;
  end
endmodule

// File: tb/test_simd_lane_adder.sv
module test_simd_lane_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sub = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [63:0] sum;
  logic [7:0]  carry;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_lane_adder i_simd_lane_adder (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .sub_i(sub),
    .a_i(a), .b_i(b), .sum_o(sum), .carry_o(carry)
  );

  task automatic model(input logic [1:0] m, input logic s, input logic [63:0] x, input logic [63:0] y,
                       output logic [63:0] rs, output logic [7:0] rc);
    int L;
    logic [64:0] mask, xv, yv, r;
    L = 8 << m;
    mask = (65'd1 << L) - 65'd1;
    rs = '0;
    rc = '0;
    for (int i = 0; i < 64 / L; i++) begin
      xv = ({1'b0, x} >> (i * L)) & mask;
      yv = ({1'b0, y} >> (i * L)) & mask;
      r  = s ? xv + (~yv & mask) + 65'd1 : xv + yv;
      rs = rs | (64'((r & mask)) << (i * L));
      rc[(i + 1) * (L / 8) - 1] = r[L];
    end
  endtask

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] m, input logic s,
                       input logic [63:0] x, input logic [63:0] y);
    logic [63:0] es;
    logic [7:0]  ec;
    model(m, s, x, y, es, ec);
    @(negedge clk);
    mode = m; sub = s; a = x; b = y;
    @(negedge clk);
    check(req, "sum", sum, es);
    check({req, " R8 R9"}, "carry", {56'd0, carry}, {56'd0, ec});
  endtask

  task automatic test_reset();
    a = '1; b = '1;
    @(negedge clk);
    check("R1", "sum in reset", sum, 64'd0);
    check("R1", "carry in reset", {56'd0, carry}, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic test_latency();
    logic [63:0] es;
    logic [7:0]  ec;
    model(2'b11, 1'b0, 64'd5, 64'd7, es, ec);
    @(negedge clk);
    mode = 2'b11; sub = 1'b0; a = 64'd5; b = 64'd7;
    @(posedge clk);
    #1;
    a = 64'd100;
    @(negedge clk);
    check("R2", "sum held after capture edge", sum, es);
    @(negedge clk);
    check("R2", "sum after next edge", sum, 64'd107);
  endtask

  task automatic test_bytes();
    apply("R3", 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    apply("R3", 2'b00, 1'b0, 64'h807F_10FE_0080_C3A5, 64'h8001_F002_0080_3C5B);
  endtask

  task automatic test_halves();
    apply("R4", 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001);
    apply("R4", 2'b01, 1'b0, 64'h8000_7FFF_00FF_1234, 64'h8000_0001_FF01_EDCC);
  endtask

  task automatic test_words();
    apply("R5", 2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001);
    apply("R5", 2'b10, 1'b0, 64'h1234_5678_8000_0000, 64'h0FED_CBA8_8000_0000);
  endtask

  task automatic test_full();
    apply("R6", 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    apply("R6", 2'b11, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
  endtask

  task automatic test_subtract();
    apply("R7", 2'b00, 1'b1, 64'h0005_0010_FF00_8001, 64'h0105_0001_01FF_7F02);
    apply("R7", 2'b01, 1'b1, 64'h0000_1234_FFFF_8000, 64'h0001_1234_0001_8001);
    apply("R7", 2'b10, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0001_7FFF_FFFF);
    apply("R7", 2'b11, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001);
    apply("R7", 2'b11, 1'b1, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001);
  endtask

  task automatic test_carry_slots();
    apply("R9", 2'b01, 1'b0, 64'hFF00_FF00_FF00_FF00, 64'h0100_0100_0100_0100);
    apply("R9", 2'b10, 1'b0, 64'h00FF_FFFF_FF00_0000, 64'h0001_0000_0100_0000);
  endtask

  initial begin
    test_reset();
    test_latency();
    test_bytes();
    test_halves();
    test_words();
    test_full();
    test_subtract();
    test_carry_slots();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule